// File: doc/BRIEF.md
# Dual-Edge Pixel Serializer

This block takes one 24-bit RGB pixel per pixel period and puts it on a narrow output bus for a display link. In double-rate mode, each pixel is split into two 12-bit halves that go out in consecutive cycles of a clock running at twice the pixel rate. The output clock marker toggles every cycle, so each edge of the modelled output clock carries one half. A configuration bit picks the order of the halves, so a receiver can expect either the low half first or the high half first. In single-rate mode, the whole 24-bit pixel goes out unchanged and is held for both cycles of the pixel period.

The block runs entirely on the double-rate clock. A phase toggle marks the first and second cycle of each pixel period. The toggle runs freely while no line is active, and it restarts on the rising edge of data-enable, so every line begins with a first half. The pixel source holds each pixel and its syncs for two cycles. Generating the physical output clock and the pad cells is left to the surrounding logic.

Top module: `dual_edge_serializer`

## Requirements
- R1: While `rstN` is low, `dataOut`, `deOut`, `hsOut`, `vsOut` and `outClk` are all zero. The first cycle after reset is a first-half cycle.
- R2: With `ddrEn` = 0 and `deIn` high, `dataOut` carries the full 24-bit pixel that was sampled in the pixel's first cycle. It appears one clock after that cycle and is held through the second cycle.
- R3: With `ddrEn` = 1 and `edgeSel` = 1 (little-endian order), `dataOut[11:0]` carries pixel bits [11:0] in the first-half output cycle and bits [23:12] in the second. `dataOut[23:12]` is zero.
- R4: With `ddrEn` = 1 and `edgeSel` = 0 (big-endian order), `dataOut[11:0]` carries pixel bits [23:12] in the first-half output cycle and bits [11:0] in the second. `dataOut[23:12]` is zero.
- R5: The pixel is sampled only in a first-half cycle. The value on `pixIn` during a second-half cycle has no effect on `dataOut`.
- R6: A cycle in which `deIn` is high after a cycle in which it was low is always a first-half cycle, whatever the phase of the free-running toggle. Outside such cycles, first and second halves alternate every clock.
- R7: In a cycle with `deIn` low, the next value of `dataOut` is zero, in both phases and both modes.
- R8: `deOut`, `hsOut` and `vsOut` take the values of `deIn`, `hsIn` and `vsIn` from first-half cycles only, one clock later. They hold their values through second-half cycles, so the syncs stay aligned with the first half.
- R9: `outClk` is registered. After a first-half cycle it equals `fourPhase`. After a second-half cycle it equals the inverse of `fourPhase`. When `fourPhase` is 1, the rising edge of `outClk` therefore leads the first half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock (two cycles per pixel) |
| rstN | input | 1 | Active-low synchronous reset |
| ddrEn | input | 1 | 1: split each pixel into two halves; 0: full-width pass-through |
| fourPhase | input | 1 | Output clock alignment: 1 puts the rising edge on the first half |
| edgeSel | input | 1 | 1: low half first; 0: high half first |
| pixIn | input | 24 | Input pixel, held for two cycles |
| deIn | input | 1 | Input data enable |
| hsIn | input | 1 | Input horizontal sync |
| vsIn | input | 1 | Input vertical sync |
| dataOut | output | 24 | Output data; in double-rate mode only bits [11:0] carry data |
| deOut | output | 1 | Data enable, aligned with the first half |
| hsOut | output | 1 | Horizontal sync, aligned with the first half |
| vsOut | output | 1 | Vertical sync, aligned with the first half |
| outClk | output | 1 | Modelled output clock level, toggles each cycle |

## Verification
Every output is one register away from the inputs. A cycle's data half, syncs and clock level are therefore due exactly one clock after the inputs that produce them. The bench drives each cycle's inputs on the falling edge and compares the outputs on the next falling edge. It keeps its own count of the first/second phase, which it restarts when data-enable rises, and from that count it predicts the half, hold and sync values for each cycle. In second-half cycles the bench deliberately drives an inverted pixel, so that any late sample shows up at once as a mismatch on the bus.

// File: rtl/des_pkg.sv
package des_pkg;
  typedef struct packed {
    logic sendFirst;
    logic dataOn;
  } serStrobe_t;
endpackage

// File: rtl/des_ctrl.sv
module des_ctrl
  import des_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       deIn,
  input  logic       hsIn,
  input  logic       vsIn,
  input  logic       fourPhase,
  output serStrobe_t strobe,
  output logic       deOut,
  output logic       hsOut,
  output logic       vsOut,
  output logic       outClk
);
  logic dePrevQ;
  logic secondNextQ;
  logic lineStart;
  logic firstNow;

  // A new line forces the first half; otherwise the phase alternates.
  assign lineStart = deIn & ~dePrevQ;
  assign firstNow  = lineStart | ~secondNextQ;

  assign strobe.sendFirst = firstNow;
  assign strobe.dataOn    = deIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dePrevQ     <= 1'b0;
      secondNextQ <= 1'b0;
      deOut       <= 1'b0;
      hsOut       <= 1'b0;
      vsOut       <= 1'b0;
      outClk      <= 1'b0;
    end else begin
      dePrevQ     <= deIn;
      secondNextQ <= firstNow;
      outClk      <= fourPhase ? firstNow : ~firstNow;
      if (firstNow) begin
        deOut <= deIn;
        hsOut <= hsIn;
        vsOut <= vsIn;
      end
    end
  end
endmodule

// File: rtl/des_datapath.sv
module des_datapath
  import des_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobe_t       strobe,
  input  logic             ddrEn,
  input  logic             edgeSel,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] dataOut
);
  localparam int HALF_W = PIX_W / 2;

  logic [PIX_W-1:0]  holdQ;
  logic [PIX_W-1:0]  srcPix;
  logic [HALF_W-1:0] loHalf;
  logic [HALF_W-1:0] hiHalf;
  logic              takeLow;
  logic [PIX_W-1:0]  nextData;

  assign srcPix  = strobe.sendFirst ? pixIn : holdQ;
  assign loHalf  = srcPix[HALF_W-1:0];
  assign hiHalf  = srcPix[PIX_W-1:HALF_W];
  // Little-endian order sends the low half in the first-half cycle.
  assign takeLow = (strobe.sendFirst == edgeSel);

  always_comb begin
    if (!strobe.dataOn)
      nextData = '0;
    else if (ddrEn)
      nextData = {{(PIX_W-HALF_W){1'b0}}, (takeLow ? loHalf : hiHalf)};
    else
      nextData = srcPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ   <= '0;
      dataOut <= '0;
    end else begin
      if (strobe.sendFirst) holdQ <= pixIn;
      dataOut <= nextData;
    end
  end
endmodule

// File: rtl/dual_edge_serializer.sv
module dual_edge_serializer
  import des_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ddrEn,
  input  logic             fourPhase,
  input  logic             edgeSel,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  output logic [PIX_W-1:0] dataOut,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut,
  output logic             outClk
);
  serStrobe_t ctlStrobe;

  des_ctrl ctrlU (
    .clk      (clk),
    .rstN     (rstN),
    .deIn     (deIn),
    .hsIn     (hsIn),
    .vsIn     (vsIn),
    .fourPhase(fourPhase),
    .strobe   (ctlStrobe),
    .deOut    (deOut),
    .hsOut    (hsOut),
    .vsOut    (vsOut),
    .outClk   (outClk)
  );

  des_datapath #(.PIX_W(PIX_W)) dpU (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctlStrobe),
    .ddrEn  (ddrEn),
    .edgeSel(edgeSel),
    .pixIn  (pixIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/dual_edge_serializer_chk.sv
module dual_edge_serializer_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             ddrEn,
  input logic             fourPhase,
  input logic             edgeSel,
  input logic [PIX_W-1:0] pixIn,
  input logic             deIn,
  input logic [PIX_W-1:0] dataOut,
  input logic             deOut,
  input logic             hsOut,
  input logic             vsOut,
  input logic             outClk,
  input logic             sendFirst
);
  localparam int HALF_W = PIX_W / 2;

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sendFirst |=> $stable(deOut) && $stable(hsOut) && $stable(vsOut)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !deIn |=> dataOut == '0); // R7

  AST_DDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ddrEn |=> dataOut[PIX_W-1:HALF_W] == '0); // R3

  AST_LINE_FIRST_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deIn) && ddrEn && edgeSel |=> dataOut[HALF_W-1:0] == $past(pixIn[HALF_W-1:0])); // R6

  AST_CLK_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    sendFirst |=> outClk == $past(fourPhase)); // R9
endmodule

bind dual_edge_serializer dual_edge_serializer_chk #(.PIX_W(PIX_W)) chkU (
  .clk      (clk),
  .rstN     (rstN),
  .ddrEn    (ddrEn),
  .fourPhase(fourPhase),
  .edgeSel  (edgeSel),
  .pixIn    (pixIn),
  .deIn     (deIn),
  .dataOut  (dataOut),
  .deOut    (deOut),
  .hsOut    (hsOut),
  .vsOut    (vsOut),
  .outClk   (outClk),
  .sendFirst(ctlStrobe.sendFirst)
);

// File: tb/dual_edge_serializer_test.sv
`timescale 1ns/1ps
module dual_edge_serializer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ddrEn = 1'b0;
  logic        fourPhase = 1'b0;
  logic        edgeSel = 1'b0;
  logic [23:0] pixIn = '0;
  logic        deIn = 1'b0;
  logic        hsIn = 1'b0;
  logic        vsIn = 1'b0;
  logic [23:0] dataOut;
  logic        deOut, hsOut, vsOut, outClk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cycNo = 0;

  // bench model state
  bit          mPrevDe = 0;
  bit          mNextSecond = 0;
  logic [23:0] mHeld = '0;
  bit          expDe = 0, expHs = 0, expVs = 0;

  always #2 clk = ~clk;

  dual_edge_serializer uut (
    .clk(clk), .rstN(rstN), .ddrEn(ddrEn), .fourPhase(fourPhase),
    .edgeSel(edgeSel), .pixIn(pixIn), .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn),
    .dataOut(dataOut), .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut),
    .outClk(outClk)
  );

  task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                     input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cycNo);
    end
  endtask

  // Drive one clock's inputs (called at a falling edge), predict, then check.
  task automatic runCycle(input logic [23:0] p, input bit d, input bit h, input bit v);
    bit first, takeLow, isStart;
    logic [23:0] src, expData;
    bit expClk;
    string tag;
    pixIn = p; deIn = d; hsIn = h; vsIn = v;
    isStart = d && !mPrevDe;
    first = isStart || !mNextSecond;
    if (first) mHeld = p;
    src = first ? p : mHeld;
    if (!d) expData = '0;
    else if (!ddrEn) expData = src;
    else begin
      takeLow = (first == edgeSel);
      expData = {12'h000, (takeLow ? src[11:0] : src[23:12])};
    end
    if (first) begin expDe = d; expHs = h; expVs = v; end
    expClk = fourPhase ? first : !first;
    if (!d) tag = "R7";
    else if (isStart) tag = "R6";
    else if (!first) tag = "R5";
    else if (!ddrEn) tag = "R2";
    else if (edgeSel) tag = "R3";
    else tag = "R4";
    mPrevDe = d;
    mNextSecond = first;
    @(negedge clk);
    cycNo++;
    chk(dataOut == expData, tag, dataOut, expData);
    chk(deOut == expDe, "R8 de", {23'd0, deOut}, {23'd0, expDe});
    chk(hsOut == expHs && vsOut == expVs, "R8 sync", {22'd0, hsOut, vsOut},
        {22'd0, expHs, expVs});
    chk(outClk == expClk, "R9", {23'd0, outClk}, {23'd0, expClk});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk(dataOut == '0, "R1 data", dataOut, '0);
    chk({deOut, hsOut, vsOut, outClk} == 4'b0, "R1 ctl",
        {20'd0, deOut, hsOut, vsOut, outClk}, '0);
    rstN = 1'b1;
    for (int combo = 0; combo < 6; combo++) begin
      ddrEn     = (combo >= 2);
      edgeSel   = (combo == 2 || combo == 3);
      fourPhase = combo[0];
      // idle stretch of varying length so the free-running phase differs
      for (int k = 0; k < 3 + combo; k++)
        runCycle(24'hABCDEF ^ 24'(k), 1'b0, (k % 3) == 0, (k % 2) == 0);
      for (int line = 0; line < 2; line++) begin
        for (int i = 0; i < 6; i++) begin
          logic [23:0] px;
          px = 24'(i * 24'h1A3B5 + combo * 24'h0F0F1 + line * 24'h30201 + 24'h5A5A5A);
          runCycle(px, 1'b1, (i % 3) == 0, (i % 4) == 1);
          // second half: inverted pixel and changed syncs must not leak (R5, R8)
          runCycle(~px, 1'b1, (i % 3) != 0, (i % 4) != 1);
        end
        // odd idle gap, so the next line starts against the free phase (R6)
        for (int k = 0; k < 3; k++)
          runCycle(24'hFFFFFF, 1'b0, 1'b1, 1'b0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule